// File: doc/BRIEF.md
# Pin-Masked Byte Serial Writer

This block shifts bytes out over two lines of a shared general-purpose output port. One line serves as a serial clock, the other as serial data. Each line is an arbitrary bit mask within the port rather than a fixed pin. A single configuration word chooses the two masks and the bit order. The configuration is accepted only when both masks land on bits that are both writable and driven as outputs. Bytes arrive on a valid/ready stream.

For every bit, the engine performs three steps. It pulls the clock bits low, then drives the data bits to the bit's value, then raises the clock bits once the data has been stable for a set number of cycles. All other port bits keep their values. A host path can still rewrite those other bits while a byte is in flight.

If no valid configuration is present, an offered byte is consumed and dropped. An error pulse reports it, and the port does not move.

Top module: `pin_serial_writer`

## Requirements
- R1: Configuration word: bits 7:0 give the clock mask, bits 15:8 the data mask, and bit 16 the order (1 = most significant bit first). It is accepted, with no `cfg_reject` pulse, when the clock mask and the data mask each overlap `wr_mask` and each overlap `port_oe`.
- R2: Each byte is sent as 8 bits. With bit 16 set, the order is bit 7 down to bit 0; with bit 16 clear, it is bit 0 up to bit 7. Each bit's value is the level of the data bits at the rising edge of the clock bits.
- R3: Per bit, the clock bits are cleared, then the data bits are driven, and the clock bits rise only after the data bits have held their value for at least `SETUP_CYC` cycles. The data bits do not change in the cycle the clock rises.
- R4: A configuration that fails the check of R1 clears both masks, and `cfg_reject` pulses for one cycle. A byte offered afterwards is refused as in R5.
- R5: When either mask is zero, an offered byte is consumed and dropped. `wr_err` is high for exactly the one cycle after acceptance. `busy` stays low and no port bit changes.
- R6: Port bits outside the clock and data masks are never altered by the engine. A host write (`port_wr_en`) while busy updates only those bits; while idle it loads the whole port.
- R7: Between consecutive bits, including from the last bit of one byte to the first bit of a back-to-back byte, the clock bits stay high for exactly `HIGH_CYC` cycles.
- R8: `in_ready` is high only when idle, or during the final cycle of the last bit's high phase. A byte offered in that final cycle starts without a gap in `busy`.
- R9: `busy` rises the cycle after a byte is accepted and stays high for 8*(1+`SETUP_CYC`+`HIGH_CYC`) cycles per byte.
- R10: After reset the port reads `RST_VAL`, `busy`, `wr_err` and `cfg_reject` are low, `in_ready` is high, and both masks are zero.
- R11: A configuration word offered while `busy` is high is ignored: there is no `cfg_reject` pulse, and the byte in flight and later bytes keep the old masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration word present |
| cfg_word | input | 17 | Clock mask, data mask, order bit |
| wr_mask | input | PORT_W | Port bits that may be written |
| port_oe | input | PORT_W | Port bits currently driven as outputs |
| cfg_reject | output | 1 | One-cycle pulse: configuration refused |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte accepted this cycle if valid |
| wr_err | output | 1 | One-cycle pulse: byte dropped, no configuration |
| busy | output | 1 | Byte in transmission |
| port_wr_en | input | 1 | Host write to the port |
| port_wr_data | input | PORT_W | Host write value |
| port_out | output | PORT_W | Shared output port register |

## Verification
Embedded properties watch every cycle for four things: the bits outside the active masks staying put while the engine runs, the data bits holding steady across each clock rise, masks being non-zero whenever a byte is in flight, and rejection or error pulses only ever appearing with cleared masks or an idle engine. Whether the received bytes are right in both orders, and whether setup and high phases last the exact cycle counts, can only be shown by the bench's scenarios. The same holds for the busy window length, ready appearing once per byte, and configuration words ignored mid-byte. For these, a monitor rebuilds bytes from the port pins and compares them against what the driver queued.

// File: rtl/pin_serial_writer.sv
module pin_serial_writer #(
  parameter int PORT_W = 12,
  parameter int SETUP_CYC = 1,
  parameter int HIGH_CYC = 1,
  parameter logic [PORT_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [16:0]       cfg_word,
  input  logic [PORT_W-1:0] wr_mask,
  input  logic [PORT_W-1:0] port_oe,
  output logic              cfg_reject,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              wr_err,
  output logic              busy,
  input  logic              port_wr_en,
  input  logic [PORT_W-1:0] port_wr_data,
  output logic [PORT_W-1:0] port_out
);

  localparam int MAXC  = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_DAT, S_SETUP, S_HIGH} st_t;

  st_t               st;
  logic [7:0]        clk_m, dat_m, sh;
  logic              msb_q;
  logic [2:0]        bitn;
  logic [CNT_W-1:0]  cnt;
  logic [PORT_W-1:0] port_q, port_d, cm, dm, act;
  logic [PORT_W-1:0] new_cm, new_dm;

  assign cm  = PORT_W'(clk_m);
  assign dm  = PORT_W'(dat_m);
  assign act = cm | dm;
  assign new_cm = PORT_W'(cfg_word[7:0]);
  assign new_dm = PORT_W'(cfg_word[15:8]);

  wire masks_ok = (|clk_m) && (|dat_m);
  wire last     = (bitn == 3'd7);
  wire hi_done  = (st == S_HIGH) && (cnt == '0);
  wire cur_bit  = msb_q ? sh[7] : sh[0];

  assign in_ready = (st == S_IDLE) || (hi_done && last);
  wire take  = in_valid && in_ready;
  wire start = take && masks_ok;

  wire cfg_take = cfg_valid && (st == S_IDLE) && !start;
  wire cfg_good = (|(new_cm & wr_mask)) && (|(new_cm & port_oe)) &&
                  (|(new_dm & wr_mask)) && (|(new_dm & port_oe));

  assign busy     = (st != S_IDLE);
  assign port_out = port_q;

  always_comb begin
    port_d = port_q;
    if (port_wr_en)
      port_d = (st == S_IDLE) ? port_wr_data : ((port_q & act) | (port_wr_data & ~act));
    unique case (st)
      S_IDLE:  if (start) port_d = port_d & ~cm;
      S_DAT:   port_d = cur_bit ? (port_d | dm) : (port_d & ~dm);
      S_SETUP: if (cnt == '0) port_d = port_d | cm;
      S_HIGH:  if (hi_done && (!last || start)) port_d = port_d & ~cm;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      port_q     <= RST_VAL;
      clk_m      <= '0;
      dat_m      <= '0;
      msb_q      <= 1'b0;
      sh         <= '0;
      bitn       <= '0;
      cnt        <= '0;
      wr_err     <= 1'b0;
      cfg_reject <= 1'b0;
    end else begin
      port_q     <= port_d;
      wr_err     <= take && !masks_ok;
      cfg_reject <= cfg_take && !cfg_good;
      if (cfg_take) begin
        clk_m <= cfg_good ? cfg_word[7:0]  : 8'h00;
        dat_m <= cfg_good ? cfg_word[15:8] : 8'h00;
        msb_q <= cfg_word[16];
      end
      unique case (st)
        S_IDLE: if (start) begin
          sh   <= in_data;
          bitn <= '0;
          st   <= S_DAT;
        end
        S_DAT: begin
          cnt <= CNT_W'(SETUP_CYC - 1);
          st  <= S_SETUP;
        end
        S_SETUP: begin
          if (cnt == '0) begin
            cnt <= CNT_W'(HIGH_CYC - 1);
            st  <= S_HIGH;
          end else cnt <= cnt - 1'b1;
        end
        S_HIGH: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!last) begin
            bitn <= bitn + 3'd1;
            sh   <= msb_q ? (sh << 1) : (sh >> 1);
            st   <= S_DAT;
          end else if (start) begin
            sh   <= in_data;
            bitn <= '0;
            st   <= S_DAT;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_other_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !port_wr_en) |=> ((port_q & ~act) == $past(port_q & ~act)));

  p_rise_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && ((port_q & cm) == cm) && ($past(port_q & cm) == '0))
      |-> ((port_q & dm) == $past(port_q & dm)));

  p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> !busy);

  p_reject_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |-> (clk_m == 8'h00 && dat_m == 8'h00));

  p_busy_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((|clk_m) && (|dat_m)));

  p_ready_clk_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_ready) |-> ((port_q & cm) == cm));

endmodule

// File: tb/pin_serial_writer_tb.sv
module pin_serial_writer_tb;
  localparam int P  = 10;
  localparam int PW = 12;
  localparam int S  = 2;
  localparam int H  = 3;
  localparam int BUSY_LEN = 8 * (1 + S + H);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 1'b0, in_valid = 1'b0, port_wr_en = 1'b0;
  logic [16:0] cfg_word = '0;
  logic [PW-1:0] wr_mask = '1, port_oe = 12'h0FF, port_wr_data = '0;
  logic [7:0] in_data = '0;
  logic cfg_reject, in_ready, wr_err, busy;
  logic [PW-1:0] port_out;

  always #(P/2) clk = ~clk;

  pin_serial_writer #(.PORT_W(PW), .SETUP_CYC(S), .HIGH_CYC(H), .RST_VAL('0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .wr_mask(wr_mask), .port_oe(port_oe), .cfg_reject(cfg_reject),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_err(wr_err), .busy(busy), .port_wr_en(port_wr_en),
    .port_wr_data(port_wr_data), .port_out(port_out));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] expq[$];
  logic [7:0] b_clk = '0, b_dat = '0;
  bit b_msb = 0;
  logic [PW-1:0] exp_host = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic bit cfg_ok(input logic [7:0] c, input logic [7:0] d);
    logic [PW-1:0] ce, de;
    ce = PW'(c); de = PW'(d);
    return (|(ce & wr_mask)) && (|(ce & port_oe)) && (|(de & wr_mask)) && (|(de & port_oe));
  endfunction

  task automatic do_cfg(input logic [7:0] c, input logic [7:0] d, input bit msb);
    bit good;
    logic [PW-1:0] old_act;
    good = cfg_ok(c, d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_word = {msb, d, c};
    @(posedge clk); #(P/4);
    cfg_valid = 1'b0;
    chk(cfg_reject == !good, good ? "R1 accept" : "R4 reject pulse", 32'(cfg_reject), 32'(!good));
    old_act = PW'(b_clk | b_dat);
    exp_host = (exp_host & ~old_act) | (port_out & old_act);
    b_clk = good ? c : 8'h00;
    b_dat = good ? d : 8'h00;
    b_msb = msb;
    @(posedge clk); #(P/4);
    chk(cfg_reject == 1'b0, "R4 pulse one cycle", 32'(cfg_reject), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ok);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    if (ok) expq.push_back(b);
    #(P/4);
    in_valid = 1'b0;
  endtask

  task automatic host_write(input logic [PW-1:0] v);
    logic [PW-1:0] a;
    a = PW'(b_clk | b_dat);
    @(negedge clk);
    port_wr_en = 1'b1; port_wr_data = v;
    exp_host = (exp_host & a) | (v & ~a);
    @(negedge clk);
    port_wr_en = 1'b0;
  endtask

  task automatic err_byte(input logic [7:0] b, input string req);
    send_byte(b, 0);
    chk(wr_err == 1'b1, req, 32'(wr_err), 1);
    chk(busy == 1'b0, "R5 no busy on refused byte", 32'(busy), 0);
    @(posedge clk); #(P/4);
    chk(wr_err == 1'b0, "R5 error one cycle", 32'(wr_err), 0);
  endtask

  // monitor / scoreboard
  initial begin
    bit prev_lo, prev_hi, hbusy;
    int drun, hrun, nb;
    logic [PW-1:0] prev_dv, dv, a;
    logic [7:0] acc;
    logic [7:0] e;
    bit chi, clo, bv;
    prev_lo = 1; prev_hi = 0; hbusy = 1; drun = 0; hrun = 0; nb = 0; prev_dv = '0; acc = '0;
    wait (rst_n);
    forever begin
      @(posedge clk); #(P/4);
      a = PW'(b_clk | b_dat);
      chk((port_out & ~a) == (exp_host & ~a), "R6 other bits", 32'(port_out), 32'(exp_host));
      if (b_clk != 0) begin
        chi = (port_out & PW'(b_clk)) == PW'(b_clk);
        clo = (port_out & PW'(b_clk)) == '0;
        dv  = port_out & PW'(b_dat);
        if (dv == prev_dv) drun++; else drun = 0;
        if (chi && prev_lo) begin
          chk(drun >= S, "R3 data setup before clock rise", 32'(drun), 32'(S));
          bv = (dv != '0);
          acc = b_msb ? {acc[6:0], bv} : {bv, acc[7:1]};
          nb++;
          if (nb == 8) begin
            nb = 0;
            if (expq.size() == 0) chk(0, "R2 unexpected byte", 32'(acc), 0);
            else begin
              e = expq.pop_front();
              chk(acc == e, "R2 byte order", 32'(acc), 32'(e));
            end
          end
        end
        if (chi) begin
          hrun++;
          hbusy = hbusy & busy;
        end else if (clo) begin
          if (prev_hi && hbusy) chk(hrun == H, "R7 clock high length", 32'(hrun), 32'(H));
          hrun = 0; hbusy = 1;
        end
        prev_lo = clo; prev_hi = chi; prev_dv = dv;
      end
    end
  end

  initial begin
    #(P * 150000);
    chk(0, "R9 watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    int n, rdy;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #(P/4);
    chk(port_out == '0, "R10 port reset", 32'(port_out), 0);
    chk(busy == 0, "R10 busy reset", 32'(busy), 0);
    chk(in_ready == 1, "R10 ready reset", 32'(in_ready), 1);
    chk(wr_err == 0 && cfg_reject == 0, "R10 pulses low", 32'({wr_err, cfg_reject}), 0);
    err_byte(8'h55, "R10 masks zero after reset");

    // R1/R2 msb-first with busy window and ready count
    do_cfg(8'h01, 8'h02, 1);
    send_byte(8'hA5, 1);
    n = 0; rdy = 0;
    while (busy) begin
      n++;
      if (in_ready) rdy++;
      @(posedge clk); #(P/4);
    end
    chk(n == BUSY_LEN, "R9 busy length", 32'(n), 32'(BUSY_LEN));
    chk(rdy == 1, "R8 ready once while busy", 32'(rdy), 1);

    // R8 back-to-back with a host write mid-byte (R6)
    fork
      begin send_byte(8'h3C, 1); send_byte(8'h81, 1); end
      begin repeat (12) @(negedge clk); host_write(12'hABC); end
    join
    n = 0;
    @(posedge clk); #(P/4);
    while (busy) begin n++; @(posedge clk); #(P/4); end
    chk(n < BUSY_LEN, "R8 second byte no gap", 32'(n), 32'(BUSY_LEN));
    repeat (4) @(posedge clk);

    // R2 lsb-first, multi-bit data mask
    do_cfg(8'h10, 8'h60, 0);
    send_byte(8'h4B, 1);
    send_byte(8'h01, 1);
    wait (!busy); repeat (3) @(posedge clk);

    // R4 rejections
    wr_mask = 12'hFFE;
    do_cfg(8'h01, 8'h02, 1);
    err_byte(8'h77, "R4 write after reject");
    wr_mask = '1; port_oe = 12'h00F;
    do_cfg(8'h01, 8'h80, 1);
    err_byte(8'h11, "R4 data mask not driven");
    port_oe = 12'h0FF;
    do_cfg(8'h04, 8'h00, 0);
    err_byte(8'h22, "R5 zero data mask");

    // R11 configuration ignored while busy
    do_cfg(8'h04, 8'h08, 1);
    send_byte(8'hC3, 1);
    repeat (5) @(negedge clk);
    cfg_valid = 1'b1; cfg_word = 17'h00000;
    @(posedge clk); #(P/4);
    cfg_valid = 1'b0;
    chk(cfg_reject == 0, "R11 no reject while busy", 32'(cfg_reject), 0);
    @(posedge clk); #(P/4);
    chk(cfg_reject == 0, "R11 no reject next cycle", 32'(cfg_reject), 0);
    wait (!busy);
    send_byte(8'h5A, 1);
    chk(wr_err == 0, "R11 masks kept", 32'(wr_err), 0);
    wait (!busy);

    repeat (20) @(posedge clk);
    chk(expq.size() == 0, "R2 all bytes seen", 32'(expq.size()), 0);
    finish_up();
  end
endmodule